// File: doc/BRIEF.md
# Synchronous Memory Port Select and Data-Direction Control

This block is the control front end of a flow-through synchronous memory port. On each rising clock edge that the clock enable lets through, it samples a three-input chip select, a write enable and one byte-write enable per lane. From these it classifies the next cycle as a read, a write data phase or a deselected cycle. It does not contain the storage array or the burst address logic. It only tells those parts what kind of cycle is running and which byte lanes to write.

The block also drives the tri-state enable of the bidirectional data and parity lines. That enable follows an asynchronous, active-low output-enable input, but internal rules override it:

- The lines stay undriven during a write data phase.
- They stay undriven on the first cycle after the port leaves the deselected state.
- They stay undriven for as long as the port is deselected.

A clock whose enable is high does not deselect the port. It stretches the current cycle. An asynchronous, active-high sleep input quiets the port at once, and commands are ignored while it is high.

Top module: `syncmem_ctl`

## Requirements
- R1: A command is accepted only when cs1_n is 0, cs2 is 1 and cs3_n is 0 at an enabled rising edge. Any other combination makes the following cycle deselected: idle is 1, rd_cycle and wr_cycle are 0, and drive_en is 0.
- R2: When clk_en_n is 1 at a rising edge, nothing is sampled. The current cycle, its lane strobes and its masking state are all held unchanged.
- R3: With the port selected, wr_n = 0 starts a write. The next cycle is its data phase: wr_cycle is 1 and drive_en is 0 whatever oe_n is.
- R4: During a write data phase, lane_wr[i] is 1 exactly when bwe_n[i] was 0 at the command edge. Bit i covers byte lane i together with that lane's parity bit. Outside a data phase, lane_wr is all zero.
- R5: With the port selected, wr_n = 1 starts a read. The read data belongs to the very next cycle, with no extra stage: rd_cycle is 1 in that cycle, and drive_en follows the inverse of oe_n combinationally while it lasts.
- R6: In the first read cycle after a deselected cycle, drive_en stays 0 even when oe_n is 0. This also holds while that cycle is stretched by masked clocks.
- R7: After a reset, idle is 1, rd_cycle and wr_cycle are 0, drive_en is 0 and lane_wr is all zero.
- R8: While sleep is 1, drive_en, rd_cycle, wr_cycle and lane_wr are 0 and idle is 1, with no clock needed. Enabled edges during sleep leave the port deselected. The first enabled edge after sleep falls accepts a command again, and that command counts as leaving deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stretches the cycle |
| wr_n | input | 1 | Write enable, active low |
| bwe_n | input | LANES | Byte-write enables, active low, one per lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| lane_wr | output | LANES | Per-lane write strobes for the data phase |
| drive_en | output | 1 | Tri-state enable for data and parity lines |
| rd_cycle | output | 1 | Current cycle is a read |
| wr_cycle | output | 1 | Current cycle is a write data phase |
| idle | output | 1 | Current cycle is deselected |

## Verification
Every cycle classification and every lane strobe is due one enabled edge after the command that causes it. The bench therefore drives each command at a falling edge and compares the outputs at the following falling edge, half a period after the capturing edge. The effects of oe_n and sleep are asynchronous, so those checks are made 1 ns after the input changes, with no clock edge in between. Masked-clock vectors are checked at the same point, to show that the outputs did not move across the edge.

// File: rtl/syncmem_ctl.sv
module syncmem_ctl #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             clk_en_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] bwe_n,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [LANES-1:0] lane_wr,
  output logic             drive_en,
  output logic             rd_cycle,
  output logic             wr_cycle,
  output logic             idle
);

  logic             sel;
  logic             cur_rd, cur_wr, desel_q, fresh;
  logic [LANES-1:0] strb_q;

  assign sel = !cs1_n && cs2 && !cs3_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_rd  <= 1'b0;
      cur_wr  <= 1'b0;
      desel_q <= 1'b1;
      fresh   <= 1'b0;
      strb_q  <= '0;
    end else if (!clk_en_n) begin
      if (sleep || !sel) begin
        cur_rd  <= 1'b0;
        cur_wr  <= 1'b0;
        desel_q <= 1'b1;
        fresh   <= 1'b0;
        strb_q  <= '0;
      end else begin
        cur_rd  <= wr_n;
        cur_wr  <= !wr_n;
        strb_q  <= wr_n ? '0 : ~bwe_n;
        fresh   <= desel_q;
        desel_q <= 1'b0;
      end
    end
  end

  assign rd_cycle = cur_rd && !sleep;
  assign wr_cycle = cur_wr && !sleep;
  assign idle     = !(rd_cycle || wr_cycle);
  assign lane_wr  = wr_cycle ? strb_q : '0;
  assign drive_en = rd_cycle && !fresh && !oe_n;

  AST_SEL_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !(!cs1_n && cs2 && !cs3_n)) |=> (!cur_rd && !cur_wr)); // R1
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable({cur_rd, cur_wr, fresh, desel_q, strb_q})); // R2
  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cycle |-> !drive_en); // R3
  AST_STRB_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_wr) |-> wr_cycle); // R4
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_cycle, wr_cycle, idle}) == 1); // R5
  AST_FIRST_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sleep && idle && !cs1_n && cs2 && !cs3_n && wr_n) |=> !drive_en); // R6
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!drive_en && lane_wr == '0 && idle)); // R8

endmodule

// File: tb/sim_syncmem_ctl.sv
module sim_syncmem_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  // {clk_en_n, cs1_n, cs2, cs3_n, wr_n, bwe_n[1:0], oe_n, sleep,
  //  exp rd, exp wr, exp idle, exp drive, exp lane_wr[1:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    15'b0_0_1_0_1_11_0_0_1_0_0_0_00, // R6 first read after reset: masked
    15'b0_0_1_0_1_11_0_0_1_0_0_1_00, // R5 second read drives
    15'b0_0_1_0_0_10_0_0_0_1_0_0_01, // R3 R4 write lane0
    15'b0_0_1_0_1_11_1_0_1_0_0_0_00, // R5 read with oe high
    15'b1_0_1_0_0_00_1_0_1_0_0_0_00, // R2 masked edge holds read
    15'b1_0_1_0_0_00_0_0_1_0_0_1_00, // R2 stretched read, oe low
    15'b0_0_0_0_1_11_0_0_0_0_1_0_00, // R1 cs2 low
    15'b0_1_1_0_1_11_0_0_0_0_1_0_00, // R1 cs1_n high
    15'b0_0_1_1_0_00_0_0_0_0_1_0_00, // R1 cs3_n high
    15'b0_0_1_0_0_00_0_0_0_1_0_0_11, // R4 write both lanes
    15'b0_0_1_0_1_11_0_0_1_0_0_1_00, // R5 read after write drives
    15'b0_0_1_0_0_01_0_0_0_1_0_0_10, // R4 write lane1
    15'b0_0_1_0_0_11_0_0_0_1_0_0_00, // R4 write no lanes
    15'b0_1_0_1_1_11_0_0_0_0_1_0_00, // R1 deselect
    15'b0_0_1_0_1_11_0_0_1_0_0_0_00, // R6 first read after deselect
    15'b1_1_1_1_0_00_0_0_1_0_0_0_00, // R6 R2 stretched, still masked
    15'b0_0_1_0_1_11_0_0_1_0_0_1_00  // R5 next read drives
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1, clk_en_n = 1'b0, wr_n = 1'b1;
  logic [1:0] bwe_n = 2'b11;
  logic oe_n = 1'b1, sleep = 1'b0;
  logic [1:0] lane_wr;
  logic drive_en, rd_cycle, wr_cycle, idle;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncmem_ctl #(.LANES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .clk_en_n(clk_en_n), .wr_n(wr_n), .bwe_n(bwe_n), .oe_n(oe_n), .sleep(sleep),
    .lane_wr(lane_wr), .drive_en(drive_en), .rd_cycle(rd_cycle),
    .wr_cycle(wr_cycle), .idle(idle)
  );

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {rd_cycle, wr_cycle, idle, drive_en, lane_wr};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {rd,wr,idle,drv,lw}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [8:0] v);
    {clk_en_n, cs1_n, cs2, cs3_n, wr_n, bwe_n, oe_n, sleep} = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R7", 6'b001000);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][14:6]);
      @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i][5:0]);
    end
    // R5 asynchronous oe during a driving read
    oe_n = 1'b1; #1;
    check("R5 oe high", 6'b100000);
    oe_n = 1'b0; #1;
    check("R5 oe low", 6'b100100);
    // R8 sleep quiets at once and blocks commands
    sleep = 1'b1; #1;
    check("R8 sleep async", 6'b001000);
    @(negedge clk);
    check("R8 command ignored", 6'b001000);
    sleep = 1'b0; #1;
    check("R8 state cleared", 6'b001000);
    @(negedge clk);
    check("R8 R6 first read after sleep", 6'b100000);
    @(negedge clk);
    check("R8 second read drives", 6'b100100);
    // R3 write data phase ignores oe low
    wr_n = 1'b0; bwe_n = 2'b00;
    @(negedge clk);
    check("R3 write phase", 6'b010011);
    // R7 reset mid-run
    rst_n = 1'b0; #1;
    check("R7 reset mid-run", 6'b001000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule